// File: doc/BRIEF.md
# Multi-cycle 16-bit word stack machine core

This block is a small multi-cycle processor core for a 16-bit, word-addressed instruction set of 22 operations and eight general registers. Every word after the opcode describes itself: a value below 0x8000 is a 15-bit literal, 0x8000 to 0x8007 names a register, and anything higher is malformed. The opcode word is resolved the same way, so a register selector in the opcode slot runs the operation whose number that register holds. Instructions take one to four words.

The core drives a synchronous single-port word memory with a read latency of one cycle. Program space is the lower 32K words. The call/data stack sits in a dedicated region just above it: the stack pointer resets to `0x8000 + STACK_DEPTH - 1` and grows downward. A character output port (valid, ready, 8-bit data) and a character input port (valid/ready, 8-bit data) connect the core to a terminal. A `halted` output reports a normal stop, and `illegal` tells a fault stop apart from it.

The control is one state machine. `ST_FETCH` presents the PC. `ST_OPCODE` resolves the returned word and either faults, goes straight to `ST_EXEC` for one-word instructions, or starts `ST_OPERAND`. `ST_OPERAND` captures one operand word per cycle until the instruction's count is reached. `ST_EXEC` checks the operands and performs the operation; it stays there while `out` or `in` waits on its port. Reads of the stack or of memory then pass through `ST_MEMRD`. Everything else returns to `ST_FETCH`. `ST_HALT` is terminal and is entered on halt, on an empty-stack return, or on any fault. The arithmetic unit, the register file and the operand resolver are separate modules.

Top module: `sm16_core`

## Requirements
- R1: After reset the PC and all eight registers are zero, `halted` and `illegal` are low, and the first memory address presented is 0.
- R2: An operand word below 0x8000 is its own value; 0x8000+n (n = 0..7) stands for register n; a word of 0x8008 or above in any position the instruction uses makes the core halt with `illegal` high.
- R3: Opcode numbers are halt 0, set 1, push 2, pop 3, eq 4, gt 5, jmp 6, jt 7, jf 8, add 9, mult 10, mod 11, and 12, or 13, not 14, rmem 15, wmem 16, call 17, ret 18, out 19, in 20, noop 21. A resolved opcode above 21 is an illegal fault. A register selector in the opcode slot uses that register's value as the opcode.
- R4: Instruction lengths in words are 1 for halt, ret and noop; 2 for push, pop, jmp, call, out and in; 3 for set, jt, jf, not, rmem and wmem; 4 for the rest. The PC advances by the length unless control is transferred.
- R5: add and mult give the result modulo 32768; mod gives the remainder; and/or are bitwise; not gives the 15-bit inverse; eq and gt (unsigned) write 1 when true and 0 otherwise.
- R6: jt jumps to operand b when operand a is nonzero; jf jumps when operand a is zero; otherwise both fall through by 3 words. jmp jumps unconditionally.
- R7: push writes at the stack pointer and then decrements it; pop increments it and then reads. The first push lands at word `0x8000 + STACK_DEPTH - 1` (0x800F by default), and pops return values in reverse order.
- R8: call pushes the address of the next instruction (PC+2) and jumps to its operand; ret pops a word and jumps to it; ret with an empty stack halts with `illegal` low.
- R9: pop with an empty stack halts with `illegal` high.
- R10: The destination operand of set, pop, eq, gt, add, mult, mod, and, or, not, rmem and in must be a register selector 0x8000..0x8007; any other word is an illegal fault.
- R11: rmem loads the memory word at the address in operand b; wmem stores operand b at the address in operand a.
- R12: out holds `out_valid` with the low 8 bits of its operand steady until `out_ready` is seen, and each character is delivered exactly once.
- R13: in holds `in_ready` high until `in_valid` is seen, then writes `in_data` zero-extended to 16 bits into the destination register.
- R14: Once halted, `halted` and `illegal` keep their values until reset, and the core writes no memory and raises no port request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address to memory |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable |
| out_valid | output | 1 | Character available on out_data |
| out_data | output | 8 | Character to the terminal |
| out_ready | input | 1 | Terminal accepts the character |
| in_valid | input | 1 | Terminal offers a character |
| in_data | input | 8 | Character from the terminal |
| in_ready | output | 1 | Core waits for a character |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | The stop was caused by a fault |

## Verification
On every cycle the assertions check the port protocols. A pending character stays valid and stable until it is accepted, and an input request stays up until a character arrives. Once halted, the core stays silent on memory and on both ports, and `illegal` never shows without `halted`. Operand resolution, opcode numbering, the arithmetic results, the branch choices, the stack order, call/return linkage and the difference between a normal and a fault stop can only be shown by the bench's programs. The bench compares the emitted characters and the memory contents against values written down from the requirements.

// File: rtl/sm16_pkg.sv
package sm16_pkg;

    localparam int WORD_W      = 16;
    localparam int NUM_REGS    = 8;
    localparam int MAX_OPND    = 3;
    localparam int OPND_IDX_W  = 2;
    localparam int LAST_OPCODE = 21;

    typedef enum logic [4:0] {
        OP_HALT = 5'd0,  OP_SET  = 5'd1,  OP_PUSH = 5'd2,  OP_POP  = 5'd3,
        OP_EQ   = 5'd4,  OP_GT   = 5'd5,  OP_JMP  = 5'd6,  OP_JT   = 5'd7,
        OP_JF   = 5'd8,  OP_ADD  = 5'd9,  OP_MULT = 5'd10, OP_MOD  = 5'd11,
        OP_AND  = 5'd12, OP_OR   = 5'd13, OP_NOT  = 5'd14, OP_RMEM = 5'd15,
        OP_WMEM = 5'd16, OP_CALL = 5'd17, OP_RET  = 5'd18, OP_OUT  = 5'd19,
        OP_IN   = 5'd20, OP_NOOP = 5'd21
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPCODE,
        ST_OPERAND,
        ST_EXEC,
        ST_MEMRD,
        ST_HALT
    } state_e;

    // Number of operand words following the opcode word.
    function automatic logic [OPND_IDX_W-1:0] op_operands(op_e op);
        case (op)
            OP_HALT, OP_RET, OP_NOOP:                        return 2'd0;
            OP_PUSH, OP_POP, OP_JMP, OP_CALL, OP_OUT, OP_IN: return 2'd1;
            OP_SET, OP_JT, OP_JF, OP_NOT, OP_RMEM, OP_WMEM:  return 2'd2;
            default:                                         return 2'd3;
        endcase
    endfunction

    // Operations whose first operand names the register to write.
    function automatic logic op_has_dest(op_e op);
        case (op)
            OP_SET, OP_POP, OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
            OP_AND, OP_OR, OP_NOT, OP_RMEM, OP_IN: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sm16_regfile.sv
module sm16_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SEL_W-1:0]          waddr,
    input  logic [W-1:0]              wdata,
    output logic [NREG-1:0][W-1:0]    regs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/sm16_operand.sv
module sm16_operand #(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [W-1:0]              word,
    input  logic [NREG-1:0][W-1:0]    regs,
    output logic [W-1:0]              value,
    output logic                      is_reg,
    output logic                      bad
);

    logic [W-1:0] sel_base;
    logic [W-1:0] sel_end;

    assign sel_base = {1'b1, {(W-1){1'b0}}};
    assign sel_end  = sel_base + W'(NREG);

    assign is_reg = (word >= sel_base) && (word < sel_end);
    assign bad    = (word >= sel_end);
    assign value  = word[W-1] ? regs[word[SEL_W-1:0]] : word;

endmodule

// File: rtl/sm16_alu.sv
module sm16_alu
    import sm16_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e           op,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  c,
    output logic [W-1:0]  y
);

    localparam logic [W-1:0] VAL_MASK = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        unique case (op)
            OP_EQ:   y = W'(b == c);
            OP_GT:   y = W'(b > c);
            OP_ADD:  y = (b + c) & VAL_MASK;
            OP_MULT: y = (b * c) & VAL_MASK;
            OP_MOD:  y = (c == '0) ? '0 : (b % c);
            OP_AND:  y = b & c;
            OP_OR:   y = b | c;
            OP_NOT:  y = ~b & VAL_MASK;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sm16_core.sv
module sm16_core
    import sm16_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        halted,
    output logic        illegal
);

    localparam int W     = WORD_W;
    localparam int SEL_W = $clog2(NUM_REGS);
    localparam logic [W-1:0] SP_TOP = W'(32'h8000 + STACK_DEPTH - 1);

    state_e                          state, state_d;
    logic [W-1:0]                    pc, pc_d, sp, sp_d;
    op_e                             opc, dec_op;
    logic [OPND_IDX_W-1:0]           nopnd, idx;
    logic [MAX_OPND-1:0][W-1:0]      opw;
    logic                            fault_q, fault_set;

    logic [NUM_REGS-1:0][W-1:0]      regs;
    logic                            rf_we;
    logic [SEL_W-1:0]                rf_waddr;
    logic [W-1:0]                    rf_wdata;

    logic [W-1:0]                    opc_val;
    logic                            opc_isreg, opc_bad;
    logic [MAX_OPND-1:0][W-1:0]      opv;
    logic [MAX_OPND-1:0]             opr, opb;
    logic [W-1:0]                    alu_y, pc_seq;
    logic                            exec_fault;

    sm16_regfile #(.W(W), .NREG(NUM_REGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
        .wdata(rf_wdata), .regs(regs)
    );

    // Opcode word is resolved like any other operand.
    sm16_operand #(.W(W), .NREG(NUM_REGS)) u_opc_res (
        .word(mem_rdata), .regs(regs), .value(opc_val),
        .is_reg(opc_isreg), .bad(opc_bad)
    );

    for (genvar k = 0; k < MAX_OPND; k++) begin : g_opnd
        sm16_operand #(.W(W), .NREG(NUM_REGS)) u_res (
            .word(opw[k]), .regs(regs), .value(opv[k]),
            .is_reg(opr[k]), .bad(opb[k])
        );
    end

    sm16_alu #(.W(W)) u_alu (
        .op(opc), .b(opv[1]), .c(opv[2]), .y(alu_y)
    );

    assign dec_op  = op_e'(opc_val[4:0]);
    assign pc_seq  = pc + W'(nopnd) + W'(1);
    assign halted  = (state == ST_HALT);
    assign illegal = fault_q;
    assign out_data = out_valid ? opv[0][7:0] : '0;

    // Operand legality: destination must be a selector, others in range.
    always_comb begin
        exec_fault = 1'b0;
        for (int k = 0; k < MAX_OPND; k++) begin
            if (k < int'(nopnd)) begin
                if (k == 0 && op_has_dest(opc)) begin
                    if (!opr[0]) exec_fault = 1'b1;
                end else if (opb[k]) begin
                    exec_fault = 1'b1;
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_d;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            sp      <= SP_TOP;
            opc     <= OP_HALT;
            nopnd   <= '0;
            idx     <= '0;
            opw     <= '0;
            fault_q <= 1'b0;
        end else begin
            pc <= pc_d;
            sp <= sp_d;
            if (state == ST_OPCODE) begin
                opc   <= dec_op;
                nopnd <= op_operands(dec_op);
                idx   <= '0;
            end
            if (state == ST_OPERAND) begin
                opw[idx] <= mem_rdata;
                idx      <= idx + 1'b1;
            end
            if (fault_set) fault_q <= 1'b1;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state;
        pc_d      = pc;
        sp_d      = sp;
        fault_set = 1'b0;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = '0;
        out_valid = 1'b0;
        in_ready  = 1'b0;
        rf_we     = 1'b0;
        rf_waddr  = opw[0][SEL_W-1:0];
        rf_wdata  = alu_y;

        unique case (state)
            ST_FETCH: begin
                mem_addr = pc;
                state_d  = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (opc_bad || opc_val > W'(LAST_OPCODE)) begin
                    fault_set = 1'b1;
                    state_d   = ST_HALT;
                end else if (op_operands(dec_op) == '0) begin
                    state_d = ST_EXEC;
                end else begin
                    mem_addr = pc + W'(1);
                    state_d  = ST_OPERAND;
                end
            end
            ST_OPERAND: begin
                if (OPND_IDX_W'(idx + 1'b1) == nopnd) begin
                    state_d = ST_EXEC;
                end else begin
                    mem_addr = pc + W'(idx) + W'(2);
                end
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                if (exec_fault) begin
                    fault_set = 1'b1;
                    state_d   = ST_HALT;
                end else begin
                    unique case (opc)
                        OP_HALT: state_d = ST_HALT;
                        OP_SET: begin
                            rf_we = 1'b1; rf_wdata = opv[1]; pc_d = pc_seq;
                        end
                        OP_PUSH: begin
                            mem_we = 1'b1; mem_addr = sp; mem_wdata = opv[0];
                            sp_d = sp - W'(1); pc_d = pc_seq;
                        end
                        OP_POP: begin
                            if (sp == SP_TOP) begin
                                fault_set = 1'b1;
                                state_d   = ST_HALT;
                            end else begin
                                mem_addr = sp + W'(1); sp_d = sp + W'(1);
                                state_d  = ST_MEMRD;
                            end
                        end
                        OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
                        OP_AND, OP_OR, OP_NOT: begin
                            rf_we = 1'b1; pc_d = pc_seq;
                        end
                        OP_JMP: pc_d = opv[0];
                        OP_JT:  pc_d = (opv[0] != '0) ? opv[1] : pc_seq;
                        OP_JF:  pc_d = (opv[0] == '0) ? opv[1] : pc_seq;
                        OP_RMEM: begin
                            mem_addr = opv[1]; state_d = ST_MEMRD;
                        end
                        OP_WMEM: begin
                            mem_we = 1'b1; mem_addr = opv[0]; mem_wdata = opv[1];
                            pc_d = pc_seq;
                        end
                        OP_CALL: begin
                            mem_we = 1'b1; mem_addr = sp; mem_wdata = pc_seq;
                            sp_d = sp - W'(1); pc_d = opv[0];
                        end
                        OP_RET: begin
                            if (sp == SP_TOP) begin
                                state_d = ST_HALT;
                            end else begin
                                mem_addr = sp + W'(1); sp_d = sp + W'(1);
                                state_d  = ST_MEMRD;
                            end
                        end
                        OP_OUT: begin
                            out_valid = 1'b1;
                            if (out_ready) pc_d = pc_seq;
                            else           state_d = ST_EXEC;
                        end
                        OP_IN: begin
                            in_ready = 1'b1;
                            if (in_valid) begin
                                rf_we = 1'b1; rf_wdata = W'(in_data);
                                pc_d  = pc_seq;
                            end else begin
                                state_d = ST_EXEC;
                            end
                        end
                        OP_NOOP: pc_d = pc_seq;
                        default: begin
                            fault_set = 1'b1;
                            state_d   = ST_HALT;
                        end
                    endcase
                end
            end
            ST_MEMRD: begin
                state_d = ST_FETCH;
                if (opc == OP_RET) begin
                    pc_d = mem_rdata;
                end else begin
                    rf_we = 1'b1; rf_wdata = mem_rdata; pc_d = pc_seq;
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

endmodule

// File: rtl/sm16_core_chk.sv
module sm16_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halted,
    input logic       illegal,
    input logic       mem_we,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       in_valid,
    input logic       in_ready
);

    a_r14_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r14_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    a_r14_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !out_valid && !in_ready));

    a_r9_fault_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r13_in_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

endmodule

bind sm16_core sm16_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted), .illegal(illegal),
    .mem_we(mem_we), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/sm16_core_test.sv
module sm16_core_test;

    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_we, out_valid, in_ready, halted, illegal;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;

    always #10 clk = ~clk;

    sm16_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .halted(halted), .illegal(illegal)
    );

    // ---------------- memory model (program 1K words + stack 64 words)
    logic [15:0] prog [0:1023];
    logic [15:0] stk  [0:63];
    logic        clr = 1'b0, ld_en = 1'b0, stall_en = 1'b0;
    logic [15:0] ld_addr = '0, ld_data = '0;
    int          cyc = 0;
    int          writes_halted = 0;

    function automatic logic [15:0] rd(input logic [15:0] a);
        if (a < 16'd1024)                       return prog[a[9:0]];
        if (a >= 16'h8000 && a < 16'h8040)      return stk[a[5:0]];
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr) begin
            for (int i = 0; i < 1024; i++) prog[i] <= '0;
            for (int i = 0; i < 64; i++)   stk[i]  <= '0;
            writes_halted <= 0;
        end else if (ld_en) begin
            if (ld_addr < 16'd1024) prog[ld_addr[9:0]] <= ld_data;
        end else if (mem_we) begin
            if (mem_addr < 16'd1024) prog[mem_addr[9:0]] <= mem_wdata;
            else if (mem_addr >= 16'h8000 && mem_addr < 16'h8040) stk[mem_addr[5:0]] <= mem_wdata;
            if (halted) writes_halted <= writes_halted + 1;
        end
        mem_rdata <= rd(mem_addr);
    end

    always @(posedge clk) begin
        #2;
        out_ready <= stall_en ? (cyc % 3 == 0) : 1'b1;
    end

    // ---------------- scoreboard
    logic [7:0] exp_q [$];
    string      tag_q [$];
    int rd_i = 0, mon_checks = 0, mon_fail = 0, stall_seen = 0;
    logic       hold_pend = 1'b0;
    logic [7:0] hold_d = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                mon_checks++;
                if (!(out_valid && out_data == hold_d)) begin
                    mon_fail++;
                    $display("FAIL R12 stalled char dropped or changed: valid=%0b data=%h expected %h",
                             out_valid, out_data, hold_d);
                end
            end
            if (out_valid && out_ready) begin
                mon_checks++;
                if (rd_i >= exp_q.size()) begin
                    mon_fail++;
                    $display("FAIL R12 unexpected char actual=%h expected none", out_data);
                end else begin
                    if (out_data !== exp_q[rd_i]) begin
                        mon_fail++;
                        $display("FAIL %s char actual=%h expected=%h", tag_q[rd_i], out_data, exp_q[rd_i]);
                    end
                    rd_i++;
                end
            end
            hold_pend = out_valid && !out_ready;
            hold_d    = out_data;
            if (hold_pend) stall_seen++;
        end else begin
            hold_pend = 1'b0;
        end
    end

    // ---------------- driver helpers
    int checks = 0, failures = 0;
    int wp = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ch(input logic [7:0] c, input string req);
        exp_q.push_back(c);
        tag_q.push_back(req);
    endtask

    function automatic logic [15:0] rg(input int n);
        return 16'(32'h8000 + n);
    endfunction

    task automatic put(input logic [15:0] d);
        ld_en = 1'b1; ld_addr = 16'(wp); ld_data = d;
        @(posedge clk); #2;
        ld_en = 1'b0;
        wp++;
    endtask

    task automatic e1(input int op);
        put(16'(op));
    endtask
    task automatic e2(input int op, input logic [15:0] a);
        put(16'(op)); put(a);
    endtask
    task automatic e3(input int op, input logic [15:0] a, input logic [15:0] b);
        put(16'(op)); put(a); put(b);
    endtask
    task automatic e4(input int op, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        put(16'(op)); put(a); put(b); put(c);
    endtask

    task automatic begin_prog();
        rst_n = 1'b0;
        @(posedge clk); #2;
        clr = 1'b1;
        @(posedge clk); #2;
        clr = 1'b0;
        wp = 0;
    endtask

    task automatic go();
        @(negedge clk);
        chk(halted == 1'b0 && illegal == 1'b0, "R1", "flags in reset", {halted, illegal}, 0);
        chk(mem_addr == 16'h0 && mem_we == 1'b0, "R1", "first fetch address", mem_addr, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(halted == 1'b1, req, "halted reached", halted, 1);
    endtask

    task automatic end_prog(input logic exp_ill, input string req);
        repeat (8) @(negedge clk);
        chk(halted == 1'b1, "R14", "halted sticky", halted, 1);
        chk(illegal == exp_ill, req, "illegal flag", illegal, exp_ill);
        chk(writes_halted == 0, "R14", "writes after halt", writes_halted, 0);
        chk(rd_i == exp_q.size(), req, "chars delivered", rd_i, exp_q.size());
    endtask

    // ---------------- watchdog
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        $display("FAIL watchdog expired at cycle %0d expected finish earlier", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fail + 1);
        $finish;
    end

    // ---------------- programs
    initial begin
        // P1: basics, register reset values, out with stalls (R1 R4 R12)
        begin_prog();
        e2(19, rg(7));                       // out reg7 -> 0 after reset
        e3(1, rg(0), 16'h0041);              // set reg0 'A'
        e2(19, rg(0));
        e1(21);                              // noop
        e4(9, rg(1), rg(0), 16'd1);          // add reg1 = 'B'
        e2(19, rg(1));
        e2(19, 16'h0043);                    // literal 'C'
        e1(0);
        expect_ch(8'h00, "R1");
        expect_ch(8'h41, "R4");
        expect_ch(8'h42, "R4");
        expect_ch(8'h43, "R2");
        stall_en = 1'b1;
        go();
        wait_halt("R4");
        end_prog(1'b0, "R12");
        chk(stall_seen > 0, "R12", "stall cycles observed", stall_seen, 1);
        stall_en = 1'b0;

        // P2: arithmetic and memory access (R5 R11)
        begin_prog();
        e4(9,  rg(0), 16'h7fff, 16'd3);   e3(16, 16'd500, rg(0));
        e4(10, rg(1), 16'h4001, 16'd3);   e3(16, 16'd501, rg(1));
        e4(11, rg(2), 16'd100, 16'd7);    e3(16, 16'd502, rg(2));
        e3(14, rg(3), 16'h00ff);          e3(16, 16'd503, rg(3));
        e4(12, rg(4), 16'h0ff0, 16'h3c3c); e3(16, 16'd504, rg(4));
        e4(13, rg(5), 16'h0ff0, 16'h3c3c); e3(16, 16'd505, rg(5));
        e4(4,  rg(6), 16'd9, 16'd9);      e3(16, 16'd506, rg(6));
        e4(5,  rg(6), 16'd5, 16'd3);      e3(16, 16'd507, rg(6));
        e4(5,  rg(6), 16'd3, 16'd3);      e3(16, 16'd508, rg(6));
        e3(15, rg(7), 16'd503);           e3(16, 16'd509, rg(7));
        e1(0);
        go();
        wait_halt("R5");
        end_prog(1'b0, "R5");
        chk(rd(16'd500) == 16'h0002, "R5", "add wraps mod 32768", rd(16'd500), 16'h0002);
        chk(rd(16'd501) == 16'h4003, "R5", "mult mod 32768", rd(16'd501), 16'h4003);
        chk(rd(16'd502) == 16'h0002, "R5", "mod remainder", rd(16'd502), 16'h0002);
        chk(rd(16'd503) == 16'h7f00, "R5", "15-bit not", rd(16'd503), 16'h7f00);
        chk(rd(16'd504) == 16'h0c30, "R5", "and", rd(16'd504), 16'h0c30);
        chk(rd(16'd505) == 16'h3ffc, "R5", "or", rd(16'd505), 16'h3ffc);
        chk(rd(16'd506) == 16'h0001, "R5", "eq true", rd(16'd506), 1);
        chk(rd(16'd507) == 16'h0001, "R5", "gt true", rd(16'd507), 1);
        chk(rd(16'd508) == 16'h0000, "R5", "gt equal is false", rd(16'd508), 0);
        chk(rd(16'd509) == 16'h7f00, "R11", "rmem then wmem copy", rd(16'd509), 16'h7f00);

        // P3: branches (R6)
        begin_prog();
        wp = 0;   e3(7, 16'd0, 16'd100);   // jt zero falls through
        wp = 3;   e2(19, 16'h0061);
        wp = 5;   e3(7, 16'd5, 16'd20);    // jt taken
        wp = 8;   e2(19, 16'h0058); e1(0);
        wp = 20;  e2(19, 16'h0062);
        wp = 22;  e3(8, 16'd0, 16'd30);    // jf taken
        wp = 25;  e2(19, 16'h0058); e1(0);
        wp = 30;  e3(8, 16'd7, 16'd100);   // jf nonzero falls through
        wp = 33;  e2(19, 16'h0063);
        wp = 35;  e3(1, rg(2), 16'd50);
        wp = 38;  e2(6, rg(2));            // jmp via register
        wp = 40;  e2(19, 16'h0058); e1(0);
        wp = 50;  e2(19, 16'h0064); e1(0);
        wp = 100; e2(19, 16'h0058); e1(0);
        expect_ch(8'h61, "R6");
        expect_ch(8'h62, "R6");
        expect_ch(8'h63, "R6");
        expect_ch(8'h64, "R6");
        go();
        wait_halt("R6");
        end_prog(1'b0, "R6");

        // P4: stack, call and return (R7 R8)
        begin_prog();
        wp = 0;  e2(2, 16'h0011);
        wp = 2;  e2(2, 16'h0022);
        wp = 4;  e2(17, 16'd20);
        wp = 6;  e2(3, rg(0));
        wp = 8;  e2(3, rg(1));
        wp = 10; e2(19, rg(0));
        wp = 12; e2(19, rg(1));
        wp = 14; e1(18);                  // empty-stack return halts
        wp = 20; e2(19, 16'h0053);
        wp = 22; e1(18);
        expect_ch(8'h53, "R8");
        expect_ch(8'h22, "R7");
        expect_ch(8'h11, "R7");
        go();
        wait_halt("R8");
        end_prog(1'b0, "R8");
        chk(rd(16'h800F) == 16'h0011, "R7", "first push at stack top", rd(16'h800F), 16'h0011);
        chk(rd(16'h800E) == 16'h0022, "R7", "second push below", rd(16'h800E), 16'h0022);
        chk(rd(16'h800D) == 16'h0006, "R8", "call return address", rd(16'h800D), 6);

        // P5: character input (R13)
        begin_prog();
        e2(20, rg(3));
        e4(9, rg(4), rg(3), 16'd1);
        e2(19, rg(4));
        e3(16, 16'd600, rg(3));
        e1(0);
        expect_ch(8'h6c, "R13");
        go();
        while (!in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b1, "R13", "in_ready held while waiting", in_ready, 1);
        chk(rd_i == exp_q.size() - 1, "R13", "no output before input", rd_i, exp_q.size() - 1);
        @(posedge clk); #2;
        in_valid = 1'b1; in_data = 8'h6b;
        @(posedge clk); #2;
        in_valid = 1'b0;
        wait_halt("R13");
        end_prog(1'b0, "R13");
        chk(rd(16'd600) == 16'h006b, "R13", "zero-extended input", rd(16'd600), 16'h006b);

        // P6: opcode taken from a register (R3)
        begin_prog();
        e3(1, rg(5), 16'd19);
        e2(32'h8005, 16'h004d);
        e1(0);
        expect_ch(8'h4d, "R3");
        go();
        wait_halt("R3");
        end_prog(1'b0, "R3");

        // P7: opcode above 21 (R3)
        begin_prog();
        e1(22);
        go();
        wait_halt("R3");
        end_prog(1'b1, "R3");

        // P8: malformed operand word (R2)
        begin_prog();
        e2(19, 16'h0070);
        e2(19, 16'h8008);
        e2(19, 16'h0071);
        e1(0);
        expect_ch(8'h70, "R2");
        go();
        wait_halt("R2");
        end_prog(1'b1, "R2");

        // P9: literal destination (R10)
        begin_prog();
        e3(1, 16'd5, 16'd7);
        e2(19, 16'h0078);
        e1(0);
        go();
        wait_halt("R10");
        end_prog(1'b1, "R10");

        // P10: pop on empty stack (R9)
        begin_prog();
        e2(3, rg(0));
        e2(19, 16'h0078);
        e1(0);
        go();
        wait_halt("R9");
        end_prog(1'b1, "R9");

        $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
        $finish;
    end

endmodule